// File: doc/BRIEF.md
# Two-Intensity Raster Pixel Shifter

The block turns bitmap words from a display memory into two serial pixel streams for a monitor driver: a full-bright stream and a half-bright stream. Display memory is organised as rows and columns. A row counter follows the beam line by line and a column counter follows it word by word, so each fetched word is the one that belongs at the current screen position. There is no glyph generator; the processor draws characters into the bitmap. The block only serialises bits.

A display timing controller supplies a vertical sync pulse and an active-region enable. Each memory word carries one bit per pixel for each intensity plane. Both planes load together into two parallel-to-serial shift registers, so the two streams stay in lockstep. Memory access goes through a simple fetch-slot handshake. The block raises a request with a row/column address. The memory owner answers with a grant that carries both plane words. A one-word prefetch buffer hides the grant latency.

The pixel clock is the block clock. A word is consumed on the first active cycle of a line and on every `WORD_W`-th active cycle after that.

Top module: `raster_pixel_shifter`

## Requirements
- R1: While reset is held and on the first cycle after it, both pixel outputs are low, `fetch_req_o` is high, and the fetch address is row 0, column 0.
- R2: A cycle with `vsync_i` high sets the row and column address to 0 and discards any buffered word.
- R3: When `active_i` drops after an active cycle (end of line), the row address increments, the column address returns to 0, and any buffered word is discarded. Vsync takes priority over this.
- R4: `fetch_req_o` is high exactly while the prefetch buffer is empty. The address holds steady until a grant arrives. A grant that arrives on a cycle that is neither a vsync nor a line end stores both plane words and increments the column address.
- R5: Both plane registers load the buffered word on the first active cycle of a line and on every `WORD_W`-th active cycle after it. Bit `WORD_W-1` is shown first. Each pixel appears on the outputs one cycle after the active cycle that carries it.
- R6: During display, `pix_full_o` equals the current full-plane bit.
- R7: During display, `pix_half_o` equals the current half-plane bit, except that it is low whenever the full-plane bit is set (full bright wins).
- R8: On the cycle after any inactive cycle, both outputs are low.
- R9: If the buffer is empty at a load point, that whole word is shown blank on both outputs.
- R10: A line may end in the middle of a word. The rest of that word is dropped, and the next line starts again at a word boundary at column 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_i | input | 1 | Vertical sync pulse from the timing controller |
| active_i | input | 1 | Active display region enable |
| fetch_req_o | output | 1 | Prefetch buffer empty, fetch requested |
| fetch_row_o | output | ROW_W | Row address of the requested word |
| fetch_col_o | output | COL_W | Column address of the requested word |
| fetch_gnt_i | input | 1 | Fetch slot granted, data valid |
| fetch_full_i | input | WORD_W | Full-bright plane word |
| fetch_half_i | input | WORD_W | Half-bright plane word |
| pix_full_o | output | 1 | Full-bright pixel stream |
| pix_half_o | output | 1 | Half-bright pixel stream |

## Verification
The hardest case to reach is a blank word from an empty buffer at a load point. With a responsive memory this never happens. The bench therefore withholds grants for a stretch that covers a whole line, and it also draws random grant delays. A second awkward case is a grant that lands on the same edge as a line end or a vsync. Random line lengths, including ones that stop mid-word, together with short gaps and the random grant timing, produce that coincidence repeatedly.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int NPLANE  = 2;
    localparam int PL_FULL = 0;
    localparam int PL_HALF = 1;
endpackage

// File: rtl/rps_addr_gen.sv
// Row/column address counters for the display bitmap.
module rps_addr_gen #(
    parameter int ROW_W = 9,
    parameter int COL_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_clr_i,
    input  logic             line_end_i,
    input  logic             step_i,
    output logic [ROW_W-1:0] row_o,
    output logic [COL_W-1:0] col_o
);
    typedef struct packed {
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } addr_t;

    addr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (frame_clr_i) begin
            st_d.row = '0;
            st_d.col = '0;
        end else if (line_end_i) begin
            st_d.row = st_q.row + 1'b1;
            st_d.col = '0;
        end else if (step_i) begin
            st_d.col = st_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign row_o = st_q.row;
    assign col_o = st_q.col;
endmodule

// File: rtl/rps_prefetch.sv
// One-word prefetch buffer holding all intensity planes.
module rps_prefetch #(
    parameter int WORD_W = 8,
    parameter int NPLANE = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush_i,
    input  logic                         take_i,
    input  logic                         gnt_i,
    input  logic [NPLANE-1:0][WORD_W-1:0] data_i,
    output logic                         req_o,
    output logic                         step_o,
    output logic [NPLANE-1:0][WORD_W-1:0] data_o
);
    typedef struct packed {
        logic [NPLANE-1:0][WORD_W-1:0] word;
        logic                          full;
    } pf_t;

    pf_t st_d, st_q;

    assign req_o  = !st_q.full;
    assign step_o = gnt_i && !st_q.full && !flush_i;

    always_comb begin
        st_d = st_q;
        if (flush_i) begin
            st_d.full = 1'b0;
        end else if (st_q.full && take_i) begin
            st_d.full = 1'b0;
        end else if (step_o) begin
            st_d.word = data_i;
            st_d.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // An empty buffer hands out a blank word.
    assign data_o = st_q.full ? st_q.word : '0;
endmodule

// File: rtl/rps_plane_ser.sv
// Parallel-to-serial register for one intensity plane, MSB first.
module rps_plane_ser #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              shift_i,
    input  logic [WORD_W-1:0] word_i,
    output logic              msb_o
);
    typedef struct packed {
        logic [WORD_W-1:0] sh;
    } ser_t;

    ser_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i)       st_d.sh = word_i;
        else if (shift_i) st_d.sh = {st_q.sh[WORD_W-2:0], 1'b0};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign msb_o = st_q.sh[WORD_W-1];
endmodule

// File: rtl/raster_pixel_shifter.sv
module raster_pixel_shifter
    import rps_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ROW_W  = 9,
    parameter int COL_W  = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              active_i,
    output logic              fetch_req_o,
    output logic [ROW_W-1:0]  fetch_row_o,
    output logic [COL_W-1:0]  fetch_col_o,
    input  logic              fetch_gnt_i,
    input  logic [WORD_W-1:0] fetch_full_i,
    input  logic [WORD_W-1:0] fetch_half_i,
    output logic              pix_full_o,
    output logic              pix_half_o
);
    localparam int PIX_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(WORD_W - 1);

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             act;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic line_end, flush, load, shift, step;
    logic [NPLANE-1:0][WORD_W-1:0] mem_word, buf_word;
    logic [NPLANE-1:0]             plane_msb;

    assign line_end = ctl_q.act && !active_i;
    assign flush    = vsync_i || line_end;
    assign load     = active_i && (ctl_q.pix == '0);
    assign shift    = active_i && (ctl_q.pix != '0);

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.act = active_i;
        if (!active_i)              ctl_d.pix = '0;
        else if (ctl_q.pix == PIX_LAST) ctl_d.pix = '0;
        else                        ctl_d.pix = ctl_q.pix + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    rps_addr_gen #(.ROW_W(ROW_W), .COL_W(COL_W)) u_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_clr_i (vsync_i),
        .line_end_i  (line_end),
        .step_i      (step),
        .row_o       (fetch_row_o),
        .col_o       (fetch_col_o)
    );

    assign mem_word[PL_FULL] = fetch_full_i;
    assign mem_word[PL_HALF] = fetch_half_i;

    rps_prefetch #(.WORD_W(WORD_W), .NPLANE(NPLANE)) u_pf (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush_i (flush),
        .take_i  (load),
        .gnt_i   (fetch_gnt_i),
        .data_i  (mem_word),
        .req_o   (fetch_req_o),
        .step_o  (step),
        .data_o  (buf_word)
    );

    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        rps_plane_ser #(.WORD_W(WORD_W)) u_ser (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_i  (load),
            .shift_i (shift),
            .word_i  (buf_word[p]),
            .msb_o   (plane_msb[p])
        );
    end

    // Full bright takes precedence over half bright.
    assign pix_full_o = ctl_q.act && plane_msb[PL_FULL];
    assign pix_half_o = ctl_q.act && plane_msb[PL_HALF] && !plane_msb[PL_FULL];
endmodule

// File: rtl/rps_checker.sv
module rps_checker #(
    parameter int ROW_W = 9,
    parameter int COL_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             vsync_i,
    input logic             active_i,
    input logic             fetch_req_o,
    input logic             fetch_gnt_i,
    input logic [ROW_W-1:0] fetch_row_o,
    input logic [COL_W-1:0] fetch_col_o,
    input logic             pix_full_o,
    input logic             pix_half_o
);
    logic was_act;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) was_act <= 1'b0;
        else        was_act <= active_i;
    end

    logic eol;
    assign eol = was_act && !active_i;

    assert_dark_outside_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !was_act |-> (!pix_full_o && !pix_half_o));

    assert_full_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(pix_full_o && pix_half_o));

    assert_frame_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        vsync_i |=> (fetch_row_o == '0 && fetch_col_o == '0 && fetch_req_o));

    assert_line_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (eol && !vsync_i) |=> (fetch_row_o == ROW_W'($past(fetch_row_o) + 1'b1)
                               && fetch_col_o == '0));

    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && !fetch_gnt_i && !vsync_i && !eol)
            |=> ($stable(fetch_col_o) && $stable(fetch_row_o)));

    assert_grant_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req_o && fetch_gnt_i && !vsync_i && !eol)
            |=> (fetch_col_o == COL_W'($past(fetch_col_o) + 1'b1) && !fetch_req_o));
endmodule

bind raster_pixel_shifter rps_checker #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .vsync_i     (vsync_i),
    .active_i    (active_i),
    .fetch_req_o (fetch_req_o),
    .fetch_gnt_i (fetch_gnt_i),
    .fetch_row_o (fetch_row_o),
    .fetch_col_o (fetch_col_o),
    .pix_full_o  (pix_full_o),
    .pix_half_o  (pix_half_o)
);

// File: tb/raster_pixel_shifter_test.sv
module raster_pixel_shifter_test;
    localparam int W  = 8;
    localparam int RW = 9;
    localparam int CW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic vsync_i = 1'b0, active_i = 1'b0, fetch_gnt_i = 1'b0;
    logic [W-1:0] fetch_full_i = '0, fetch_half_i = '0;
    logic fetch_req_o, pix_full_o, pix_half_o;
    logic [RW-1:0] fetch_row_o;
    logic [CW-1:0] fetch_col_o;

    int checks = 0, errors = 0;
    bit done = 0;

    raster_pixel_shifter #(.WORD_W(W), .ROW_W(RW), .COL_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .active_i(active_i),
        .fetch_req_o(fetch_req_o), .fetch_row_o(fetch_row_o), .fetch_col_o(fetch_col_o),
        .fetch_gnt_i(fetch_gnt_i), .fetch_full_i(fetch_full_i), .fetch_half_i(fetch_half_i),
        .pix_full_o(pix_full_o), .pix_half_o(pix_half_o)
    );

    always #2 clk = ~clk;

    function automatic logic [W-1:0] memf(input int r, input int c);
        return W'((r * 29) ^ (c * 71) ^ 8'h5A);
    endfunction
    function automatic logic [W-1:0] memh(input int r, input int c);
        return W'((r * 13 + c * 53) ^ 8'hC3);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model state
    bit m_v = 0;
    int m_row = 0, m_col = 0, m_pix = 0, off = 0, waitc = 0;
    logic [W-1:0] bf = '0, bh = '0, cw_f = '0, cw_h = '0;
    bit drv_prev = 0, exp_f = 0, exp_h = 0, exp_act = 0, blank_word = 0;
    bit block = 0;

    task automatic tick(input bit act_n, input bit vs_n);
        bit g, fl, ld;
        @(negedge clk);
        if (!exp_act) begin
            chk("R8 full", pix_full_o, 0);
            chk("R8 half", pix_half_o, 0);
        end else if (blank_word) begin
            chk("R9 full", pix_full_o, 0);
            chk("R9 half", pix_half_o, 0);
        end else begin
            chk("R5,R6 full", pix_full_o, exp_f);
            chk("R7 half", pix_half_o, exp_h);
        end
        chk("R4 req", fetch_req_o, !m_v);
        if (!m_v) begin
            chk("R2,R3 row", fetch_row_o, m_row % (1 << RW));
            chk("R2,R3 col", fetch_col_o, m_col % (1 << CW));
        end
        g = !m_v && !block && (waitc >= 3 || ($urandom % 2) == 1);
        waitc = (!m_v && !g) ? waitc + 1 : 0;
        active_i = act_n; vsync_i = vs_n; fetch_gnt_i = g;
        fetch_full_i = memf(m_row, m_col); fetch_half_i = memh(m_row, m_col);
        // model the coming edge
        fl = vs_n || (drv_prev && !act_n);
        ld = act_n && (m_pix == 0);
        if (ld) begin
            cw_f = m_v ? bf : '0; cw_h = m_v ? bh : '0;
            blank_word = !m_v; off = 0;
        end else if (act_n) off++;
        exp_act = act_n;
        exp_f = act_n && cw_f[W-1-off];
        exp_h = act_n && cw_h[W-1-off] && !exp_f;
        if (fl) begin
            m_v = 0; m_col = 0; waitc = 0;
            m_row = vs_n ? 0 : m_row + 1;
        end else if (m_v && ld) begin
            m_v = 0;
        end else if (!m_v && g) begin
            bf = memf(m_row, m_col); bh = memh(m_row, m_col);
            m_v = 1; m_col++;
        end
        m_pix = !act_n ? 0 : (m_pix == W - 1 ? 0 : m_pix + 1);
        drv_prev = act_n;
    endtask

    task automatic line(input int len, input int gap);
        for (int i = 0; i < len; i++) tick(1, 0);
        for (int i = 0; i < gap; i++) tick(0, 0);
    endtask

    task automatic vsync_pulse();
        tick(0, 1);
        for (int i = 0; i < 10; i++) tick(0, 0);
    endtask

    initial begin
        #800000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(posedge clk);
        @(negedge clk);
        chk("R1 full", pix_full_o, 0);
        chk("R1 half", pix_half_o, 0);
        chk("R1 req", fetch_req_o, 1);
        chk("R1 row", fetch_row_o, 0);
        chk("R1 col", fetch_col_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req after release", fetch_req_o, 1);
        chk("R1 col after release", fetch_col_o, 0);
        // directed: whole-word lines
        vsync_pulse();
        line(4 * W, 10);
        line(4 * W, 10);
        // R10: lines ending mid-word
        line(13, 9);
        line(W + 1, 9);
        line(1, 9);
        // R9: grants withheld across a line -> blank words
        block = 1;
        line(3 * W, 9);
        line(2 * W + 3, 4);
        block = 0;
        for (int i = 0; i < 6; i++) tick(0, 0);
        line(3 * W, 10);
        // vsync mid-frame resets row (R2)
        vsync_pulse();
        line(2 * W, 10);
        // random frames
        for (int f = 0; f < 4; f++) begin
            vsync_pulse();
            for (int l = 0; l < 8; l++)
                line(1 + ($urandom % 70), 8 + ($urandom % 8));
        end
        tick(0, 0); tick(0, 0);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule